// File: doc/BRIEF.md
# MSI Message Composer

This block forms the single memory write that signals a message-signalled interrupt for a function that owns one or more interrupt vectors. It keeps the capability state: a shared message address, a shared 16-bit message data word, the enable bit, the count the function can support and the count software has granted. A requester presents a vector index. The block checks the index against the granted count and then issues one write request. The write carries the shared address and a 32-bit payload whose low 16 bits are the shared data word, with its low bits overwritten by the vector index.

The granted count is a power of two from 1 to 32, written as its base-2 logarithm. Granted vectors form one contiguous block, so a granted count of 2^e overwrites exactly e low data bits. Because there is only one address, every vector of the function reaches the same processor. A separate combinational helper builds the address and data words from a destination processor ID and an interrupt vector number, using physical destination, no redirection hint, fixed delivery and edge trigger.

The control path is a three-state machine. ST_IDLE waits for a request. ST_SEND presents the write until it is accepted. ST_FAULT raises the error flag for one cycle. The transitions are T_ACCEPT (ST_IDLE to ST_SEND on a valid in-range request while enabled), T_REJECT (ST_IDLE to ST_FAULT on an out-of-range request while enabled), T_DISCARD (ST_IDLE stays in ST_IDLE on a request while disabled), T_DRAIN (ST_SEND to ST_IDLE when the write is accepted) and T_RECOVER (ST_FAULT to ST_IDLE unconditionally).

Top module: `msi_msg_composer`

## Requirements
- R1: After reset, wr_valid and req_err are 0, req_ready is 1, the enable bit is clear and all capability registers are zero.
- R2: Configuration writes use cfg_sel 0 for the address, 1 for the data word (cfg_wdata[15:0]) and 2 for control. In the control word, bit 0 is enable, bits 3:1 are the supported count exponent and bits 6:4 are the granted count exponent. The effective exponent e is the smallest of granted, supported and 5, and the vector count is 2^e.
- R3: For an accepted vector v, wr_payload[15:0] equals the stored data word with its low e bits replaced by the low e bits of v, and wr_payload[31:16] is zero.
- R4: wr_addr equals the stored address with bits 1:0 forced to zero, and it is the same for every vector.
- R5: A request with index v >= 2^e while enabled issues no write. req_err is high for exactly the one cycle after the request edge.
- R6: A request made while the enable bit is clear is discarded, with no write and no error.
- R7: A request accepted at a clock edge raises wr_valid after that edge. wr_valid, wr_addr and wr_payload hold until wr_ready is sampled high, and wr_valid is low after that edge.
- R8: req_ready is low while a write is outstanding or the error cycle is shown. A request in the same cycle as a configuration write is judged against, and built from, the configuration held before that write.
- R9: hlp_addr equals 0xFEE00000 with hlp_cpu placed in bits 19:12 and bits 3 and 2 (redirection hint, destination mode) zero.
- R10: hlp_data carries hlp_vector in bits 7:0, delivery mode 000 in bits 10:8, trigger bit 15 at 0, and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Capability register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 5 | Vector index of the request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_err | output | 1 | One-cycle flag for an out-of-range index |
| wr_valid | output | 1 | Memory write request pending |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | 32 | Write address |
| wr_payload | output | 32 | Write payload |
| hlp_cpu | input | 8 | Helper: destination processor ID |
| hlp_vector | input | 8 | Helper: interrupt vector number |
| hlp_addr | output | 32 | Helper: formed message address |
| hlp_data | output | 16 | Helper: formed message data |

## Verification
A configuration write and a request can land on the same clock edge. In that case the register update and the range check plus payload build happen together. The bench provokes this in two ways. It clears the enable bit and rewrites the data word in the very cycle a request is strobed. It then judges the result by requiring that the write still issues and carries the payload computed from the old data word. The sweep over every supported and granted exponent pair, with all 32 indices, covers the clamp, the bit replacement and the rejection boundary.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 16;
    localparam int PAYLOAD_W = 32;
    localparam int VEC_W     = 5;
    localparam int EXP_W     = 3;
    localparam int CPU_W     = 8;
    localparam int IVEC_W    = 8;
    localparam int SEL_W     = 2;

    localparam logic [SEL_W-1:0] SEL_ADDR = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;

    localparam logic [ADDR_W-1:0] LAPIC_BASE = 32'hFEE0_0000;

    typedef struct packed {
        logic [EXP_W-1:0] grant_exp;
        logic [EXP_W-1:0] cap_exp;
        logic             enable;
    } msi_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_FAULT = 2'd2
    } msi_state_t;

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int WW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [WW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cap_addr,
    output logic [DW-1:0]    cap_data,
    output msi_ctrl_t        cap_ctrl
);

    localparam int CTRL_W = $bits(msi_ctrl_t);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    msi_ctrl_t     ctrl_q;

    // Address is dword aligned: the two low bits never store a one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_ADDR) begin
            addr_q <= {cfg_wdata[AW-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_DATA) begin
            data_q <= cfg_wdata[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_CTRL) begin
            ctrl_q <= msi_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    assign cap_addr = addr_q;
    assign cap_data = data_q;
    assign cap_ctrl = ctrl_q;

endmodule

// File: rtl/msi_vec_span.sv
module msi_vec_span
    import msi_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int EW = EXP_W
) (
    input  logic [EW-1:0] cap_exp,
    input  logic [EW-1:0] grant_exp,
    input  logic [VW-1:0] vec,
    output logic [EW-1:0] span_exp,
    output logic          vec_in_range
);

    localparam logic [EW-1:0] SPAN_MAX = EW'(VW);

    logic [EW-1:0] granted_clamped;
    logic [VW:0]   limit;

    always_comb begin
        // Software may not grant more than the function can support.
        granted_clamped = (grant_exp > cap_exp) ? cap_exp : grant_exp;
        // Encodings past the largest legal count mean the full block.
        span_exp = (granted_clamped > SPAN_MAX) ? SPAN_MAX : granted_clamped;
        limit = (VW+1)'(1) << span_exp;
        vec_in_range = ({1'b0, vec} < limit);
    end

endmodule

// File: rtl/msi_data_merge.sv
module msi_data_merge
    import msi_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = VEC_W,
    parameter int EW = EXP_W
) (
    input  logic [DW-1:0] base_data,
    input  logic [VW-1:0] vec,
    input  logic [EW-1:0] span_exp,
    output logic [DW-1:0] merged
);

    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_bit
            if (gi < VW) begin : g_low
                localparam int unsigned IDX = gi;
                // Bit gi belongs to the vector field when the span covers it.
                assign merged[gi] = (32'(span_exp) > IDX) ? vec[gi] : base_data[gi];
            end else begin : g_high
                assign merged[gi] = base_data[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/msi_word_former.sv
module msi_word_former
    import msi_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int CW  = CPU_W,
    parameter int IVW = IVEC_W,
    parameter int CPU_LSB = 12
) (
    input  logic [CW-1:0]  cpu_id,
    input  logic [IVW-1:0] int_vector,
    output logic [AW-1:0]  msg_addr,
    output logic [DW-1:0]  msg_data
);

    localparam int RH_BIT   = 3;
    localparam int DM_BIT   = 2;
    localparam int TRIG_BIT = 15;
    localparam int LVL_BIT  = 14;
    localparam int DLV_LSB  = 8;
    localparam int DLV_W    = 3;

    localparam logic [DLV_W-1:0] DLV_FIXED = '0;

    logic [AW-1:0] dest_field;

    always_comb begin
        dest_field = AW'(cpu_id) << CPU_LSB;
        msg_addr   = LAPIC_BASE | dest_field;
        // Physical destination, no redirection hint.
        msg_addr[RH_BIT] = 1'b0;
        msg_addr[DM_BIT] = 1'b0;

        msg_data = '0;
        msg_data[IVW-1:0] = int_vector;
        msg_data[DLV_LSB +: DLV_W] = DLV_FIXED;
        msg_data[LVL_BIT]  = 1'b0;
        msg_data[TRIG_BIT] = 1'b0; // edge triggered
    end

endmodule

// File: rtl/msi_msg_composer.sv
module msi_msg_composer
    import msi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic                 req_valid,
    input  logic [VEC_W-1:0]     req_vec,
    output logic                 req_ready,
    output logic                 req_err,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [PAYLOAD_W-1:0] wr_payload,
    input  logic [CPU_W-1:0]     hlp_cpu,
    input  logic [IVEC_W-1:0]    hlp_vector,
    output logic [ADDR_W-1:0]    hlp_addr,
    output logic [DATA_W-1:0]    hlp_data
);

    localparam int PAD_W = PAYLOAD_W - DATA_W;

    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    msi_ctrl_t         cap_ctrl;
    logic [EXP_W-1:0]  span_exp;
    logic              vec_in_range;
    logic [DATA_W-1:0] merged_data;

    msi_state_t state_q, state_d;
    logic       take_req;
    logic [ADDR_W-1:0]    addr_hold_q;
    logic [PAYLOAD_W-1:0] pay_hold_q;

    msi_cap_regs #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .WW (32)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .cap_ctrl  (cap_ctrl)
    );

    msi_vec_span #(
        .VW (VEC_W),
        .EW (EXP_W)
    ) u_span (
        .cap_exp      (cap_ctrl.cap_exp),
        .grant_exp    (cap_ctrl.grant_exp),
        .vec          (req_vec),
        .span_exp     (span_exp),
        .vec_in_range (vec_in_range)
    );

    msi_data_merge #(
        .DW (DATA_W),
        .VW (VEC_W),
        .EW (EXP_W)
    ) u_merge (
        .base_data (cap_data),
        .vec       (req_vec),
        .span_exp  (span_exp),
        .merged    (merged_data)
    );

    msi_word_former #(
        .AW  (ADDR_W),
        .DW  (DATA_W),
        .CW  (CPU_W),
        .IVW (IVEC_W)
    ) u_helper (
        .cpu_id     (hlp_cpu),
        .int_vector (hlp_vector),
        .msg_addr   (hlp_addr),
        .msg_data   (hlp_data)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic with named transitions.
    always_comb begin
        state_d  = state_q;
        take_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && cap_ctrl.enable) begin
                    if (vec_in_range) begin
                        state_d  = ST_SEND;   // T_ACCEPT
                        take_req = 1'b1;
                    end else begin
                        state_d  = ST_FAULT;  // T_REJECT
                    end
                end
                // T_DISCARD: request while disabled stays in ST_IDLE.
            end
            ST_SEND: begin
                if (wr_ready) begin
                    state_d = ST_IDLE;        // T_DRAIN
                end
            end
            ST_FAULT: begin
                state_d = ST_IDLE;            // T_RECOVER
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Message capture at acceptance; held stable through ST_SEND.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold_q <= '0;
            pay_hold_q  <= '0;
        end else if (take_req) begin
            addr_hold_q <= cap_addr;
            pay_hold_q  <= {{PAD_W{1'b0}}, merged_data};
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready  = 1'b0;
        req_err    = 1'b0;
        wr_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_SEND:  wr_valid  = 1'b1;
            ST_FAULT: req_err   = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        wr_addr    = addr_hold_q;
        wr_payload = pay_hold_q;
    end

endmodule

// File: rtl/msi_msg_composer_chk.sv
module msi_msg_composer_chk
    import msi_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_err,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [PAYLOAD_W-1:0] wr_payload,
    input logic [CPU_W-1:0]     hlp_cpu,
    input logic [IVEC_W-1:0]    hlp_vector,
    input logic [ADDR_W-1:0]    hlp_addr,
    input logic [DATA_W-1:0]    hlp_data
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_payload)));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || req_err) |-> !req_ready);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err);

    assert_err_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !wr_valid);

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_err) |-> $past(req_valid && req_ready));

    assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    assert_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_payload[PAYLOAD_W-1:DATA_W] == '0));

    assert_helper_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hlp_addr[31:20] == 12'hFEE) && (hlp_addr[19:12] == hlp_cpu) && (hlp_addr[11:0] == 12'h000));

    assert_helper_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hlp_data[7:0] == hlp_vector) && (hlp_data[15:8] == 8'h00));

endmodule

bind msi_msg_composer msi_msg_composer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_payload (wr_payload),
    .hlp_cpu    (hlp_cpu),
    .hlp_vector (hlp_vector),
    .hlp_addr   (hlp_addr),
    .hlp_data   (hlp_data)
);

// File: tb/msi_msg_composer_test.sv
`timescale 1ns/1ps
module msi_msg_composer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        req_ready;
    logic        req_err;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_payload;
    logic [7:0]  hlp_cpu = '0;
    logic [7:0]  hlp_vector = '0;
    logic [31:0] hlp_addr;
    logic [15:0] hlp_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    msi_msg_composer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vec(req_vec),
        .req_ready(req_ready), .req_err(req_err), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_payload(wr_payload),
        .hlp_cpu(hlp_cpu), .hlp_vector(hlp_vector), .hlp_addr(hlp_addr),
        .hlp_data(hlp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input int en, input int cap, input int grant);
        return 32'((grant << 4) | (cap << 1) | en);
    endfunction

    // mode 0: write expected, 1: error expected, 2: discard expected
    task automatic do_req(input logic [4:0] v, input int mode, input logic [31:0] exp_addr,
                          input logic [31:0] exp_pay, input int hold, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vec = v; wr_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (mode == 0) begin
            chk(wr_valid === 1'b1, {tag, " R7 valid"}, 32'(wr_valid), 32'd1);
            chk(wr_addr === exp_addr, {tag, " R4 addr"}, wr_addr, exp_addr);
            chk(wr_payload === exp_pay, {tag, " R3 payload"}, wr_payload, exp_pay);
            chk(req_ready === 1'b0, {tag, " R8 busy"}, 32'(req_ready), 32'd0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk(wr_valid === 1'b1 && wr_payload === exp_pay && wr_addr === exp_addr,
                    {tag, " R7 hold"}, wr_payload, exp_pay);
            end
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk(wr_valid === 1'b0, {tag, " R7 drop"}, 32'(wr_valid), 32'd0);
        end else if (mode == 1) begin
            chk(req_err === 1'b1 && wr_valid === 1'b0, {tag, " R5 err"}, 32'({req_err, wr_valid}), 32'b10);
            @(negedge clk);
            chk(req_err === 1'b0 && wr_valid === 1'b0, {tag, " R5 pulse"}, 32'({req_err, wr_valid}), 32'b00);
        end else begin
            chk(req_err === 1'b0 && wr_valid === 1'b0, {tag, " R6 discard"}, 32'({req_err, wr_valid}), 32'b00);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] addr_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wr_valid === 1'b0, "R1 wr_valid", 32'(wr_valid), 0);
        chk(req_err === 1'b0, "R1 req_err", 32'(req_err), 0);
        chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
        // R1/R6: enable clear after reset, request discarded
        do_req(5'd0, 2, 0, 0, 0, "R1 reset disabled");

        cfg_write(2'd0, 32'hFEE0_3007);
        addr_exp = 32'hFEE0_3004;

        // R2/R3/R4/R5: exhaustive sweep of exponent pairs and indices
        for (int cap = 0; cap < 8; cap++) begin
            for (int gr = 0; gr < 8; gr++) begin
                int e;
                logic [15:0] base;
                logic [15:0] mask;
                e = (gr < cap) ? gr : cap;
                if (e > 5) e = 5;
                base = 16'hA5C3 ^ 16'(cap * 37 + gr * 11);
                mask = 16'((1 << e) - 1);
                cfg_write(2'd1, {16'h0, base});
                cfg_write(2'd2, ctrl_word(1, cap, gr));
                for (int v = 0; v < 32; v++) begin
                    logic [31:0] pay;
                    pay = {16'h0, (base & ~mask) | (16'(v) & mask)};
                    if (v < (1 << e))
                        do_req(5'(v), 0, addr_exp, pay, v % 3, "R2 sweep");
                    else
                        do_req(5'(v), 1, 0, 0, 0, "R5 sweep");
                end
            end
        end

        // R6: disabled with full grant, every index discarded
        cfg_write(2'd2, ctrl_word(0, 5, 5));
        for (int v = 0; v < 32; v += 7)
            do_req(5'(v), 2, 0, 0, 0, "R6 disabled");

        // R8: request and control write (disable) in same cycle
        cfg_write(2'd1, 32'h0000_1230);
        cfg_write(2'd2, ctrl_word(1, 2, 2));
        @(negedge clk);
        req_valid = 1'b1; req_vec = 5'd3;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = ctrl_word(0, 2, 2);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk(wr_valid === 1'b1, "R8 same-cycle disable", 32'(wr_valid), 1);
        chk(wr_payload === 32'h0000_1233, "R8 same-cycle payload", wr_payload, 32'h1233);
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        do_req(5'd1, 2, 0, 0, 0, "R8 after disable");

        // R8: request and data write in same cycle, old data used
        cfg_write(2'd2, ctrl_word(1, 2, 2));
        @(negedge clk);
        req_valid = 1'b1; req_vec = 5'd2;
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0000_BEE0;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk(wr_payload === 32'h0000_1232, "R8 same-cycle data", wr_payload, 32'h1232);
        // R8: request while busy is not taken
        req_valid = 1'b1; req_vec = 5'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr_payload === 32'h0000_1232, "R8 busy ignore", wr_payload, 32'h1232);
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        do_req(5'd1, 0, addr_exp, 32'h0000_BEE1, 1, "R8 new data");

        // R9/R10: helper sweep
        for (int c = 0; c < 256; c += 5) begin
            for (int iv = 0; iv < 256; iv += 51) begin
                logic [31:0] ea;
                @(negedge clk);
                hlp_cpu = 8'(c); hlp_vector = 8'(iv);
                #1;
                ea = 32'hFEE0_0000 | (32'(c) << 12);
                chk(hlp_addr === ea, "R9 helper addr", hlp_addr, ea);
                chk(hlp_data === 16'(iv), "R10 helper data", 32'(hlp_data), 32'(iv));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule